// File: doc/BRIEF.md
# Interrupt Priority and Service Tracker

This block keeps the state of 256 interrupt vectors: which ones have been requested and are waiting, and which ones the core is currently servicing. Each cycle it offers the core the most urgent waiting vector, provided that vector outranks the current processor priority. When the core takes the offered vector, the vector moves from the waiting set to the in-service set and joins a stack of nested services. An end-of-interrupt strobe retires the most urgent in-service vector.

A vector's priority class is its upper four bits. The processor priority combines a software-written task priority with the class of the innermost vector in service. Vectors 0 to 31 are reserved. They can be recorded as requested, but they are never offered. Software can read back all eight 32-bit words of both the request set and the in-service set through a word-select port.

Top module: `irq_prio_tracker`

## Requirements
- R1: After a synchronous active-low reset, all request and in-service bits read zero. The task priority, the processor priority and the overflow flag are zero, and nothing is offered.
- R2: A request strobe for vector v sets bit v%32 of request word v/32, for every v from 0 to 255, reserved vectors included.
- R3: The offered vector is the highest-numbered requested vector in the range 32..255. A vector below 32 is never offered.
- R4: The candidate from R3 is offered (pend_valid=1) only when its class (bits 7:4) is strictly greater than the class of the processor priority.
- R5: A task-priority write keeps only bits 7:0 of the write data. The processor priority equals the task priority when the task-priority class is at least the class of the innermost in-service vector. Otherwise it equals that vector with bits 3:0 cleared. Outputs reflect a change in the cycle after it.
- R6: An accept while a vector is offered and the stack is not full clears the vector's request bit, sets its in-service bit and pushes it on the nesting stack. An accept while nothing is offered has no effect.
- R7: An end-of-interrupt clears the highest set in-service bit in the range 32..255 and pops the stack, which restores the previous priority level. An end-of-interrupt with nothing in service changes nothing.
- R8: When a request strobe and an accept name the same vector in the same cycle, the request bit ends up cleared.
- R9: An accept when the stack already holds STACK_DEPTH entries changes neither the request nor the in-service state. It sets a sticky overflow flag that only reset clears.
- R10: When an effective accept and an end-of-interrupt arrive in the same cycle, the accept is applied and the end-of-interrupt is dropped.
- R11: rd_data returns in-service word rd_word when rd_isr=1, and request word rd_word when rd_isr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Vector being requested |
| pend_valid | output | 1 | A vector is offered to the core |
| pend_vector | output | 8 | Offered vector |
| ack | input | 1 | Core accepts the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 used) |
| tpr_out | output | 8 | Current task priority |
| ppr_out | output | 8 | Current processor priority |
| ovf_err | output | 1 | Sticky nesting-stack overflow flag |
| rd_isr | input | 1 | Readback selects the in-service set (1) or the request set (0) |
| rd_word | input | 3 | Readback word index |
| rd_data | output | 32 | Readback word |

## Verification
The bench targets several edge cases:
- **Equal class.** A task priority whose class equals the candidate's class must block delivery. A non-strict compare would offer that vector.
- **Reserved vectors.** These must be stored but never offered. A scan that includes word 0 would hand out vector 5.
- **Request and accept together.** When both name the same vector in one cycle, a set-after-clear ordering would leave a stale request that gets delivered twice.
- **Full stack.** Nesting to the stack limit must set the flag and leave all state untouched. A wrong limit would corrupt the priority or silently drop the vector.
- **Accept plus end-of-interrupt, and empty end-of-interrupt.** These expose a design that retires the wrong level or underflows the stack.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the interrupt priority tracker.
// Assumes 256 vectors in 8 words of 32 bits, with the low word reserved.
package irq_pkg;
    localparam int NUM_VEC   = 256;
    localparam int WORD_BITS = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_BITS;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int RSVD_VEC  = 32;

    typedef logic [VEC_W-1:0] vec_t;

    // Priority class of a vector or priority value: its upper nibble.
    function automatic logic [3:0] prio_class(input vec_t v);
        return v[VEC_W-1:VEC_W-4];
    endfunction
endpackage

// File: rtl/irq_msb_find.sv
// Finds the highest set bit of a wide vector, ignoring the bits below LOW.
// Purely combinational; assumes LOW < W.
module irq_msb_find #(
    parameter int W     = 256,
    parameter int LOW   = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Upward scan; the last hit is the most significant set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LOW; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_stack.sv
// Stack of nested in-service vectors. Slot 0 is fixed at zero and means
// "nothing in service". Assumes the caller never pushes and pops together
// and only pushes a vector of higher class than the current top.
module irq_svc_stack #(
    parameter int DEPTH = 16,
    parameter int VW    = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [VW-1:0] push_vec,
    output logic [VW-1:0] top_vec,
    output logic          full,
    output logic          empty
);
    logic [VW-1:0] slot [0:DEPTH];
    logic [PW-1:0] sp;

    assign full    = (sp == PW'(DEPTH));
    assign empty   = (sp == '0);
    assign top_vec = slot[sp];

    // Stack pointer and slot storage; slot 0 is only ever reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i <= DEPTH; i++) slot[i] <= '0;
        end else if (push && !full) begin
            sp <= sp + 1'b1;
            slot[PW'(sp + 1'b1)] <= push_vec;
        end else if (pop && !empty) begin
            sp <= sp - 1'b1;
        end
    end

    a_r9_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= PW'(DEPTH));
    a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (sp == PW'($past(sp) - 1'b1)));
    a_r6_nest_order: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !empty) |-> (push_vec[VW-1:VW-4] > top_vec[VW-1:VW-4]));
endmodule

// File: rtl/irq_prio_tracker.sv
// Interrupt priority and service tracker. Holds request and in-service bits
// for 256 vectors and offers the highest requested vector above the
// processor priority. Accept moves a vector into service, end-of-interrupt
// retires the highest one. Assumes single-cycle strobes and that ack refers
// to the vector offered in the same cycle.
module irq_prio_tracker
    import irq_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [7:0]  req_vector,
    output logic        pend_valid,
    output logic [7:0]  pend_vector,
    input  logic        ack,
    input  logic        eoi,
    input  logic        tpr_we,
    input  logic [31:0] tpr_wdata,
    output logic [7:0]  tpr_out,
    output logic [7:0]  ppr_out,
    output logic        ovf_err,
    input  logic        rd_isr,
    input  logic [2:0]  rd_word,
    output logic [31:0] rd_data
);
    logic [NUM_VEC-1:0] irr, isr;
    logic [7:0]         tpr;
    logic               ovf;

    logic               irr_found, isr_found;
    vec_t               irr_top, isr_top;
    vec_t               stk_top;
    logic               stk_full, stk_empty;
    logic               take, retire;
    logic [NUM_VEC-1:0] req_mask, take_mask, retire_mask;

    irq_msb_find #(.W(NUM_VEC), .LOW(RSVD_VEC)) u_irr_scan (
        .bits(irr), .found(irr_found), .idx(irr_top));
    irq_msb_find #(.W(NUM_VEC), .LOW(RSVD_VEC)) u_isr_scan (
        .bits(isr), .found(isr_found), .idx(isr_top));

    irq_svc_stack #(.DEPTH(STACK_DEPTH), .VW(VEC_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .pop(retire),
        .push_vec(irr_top), .top_vec(stk_top),
        .full(stk_full), .empty(stk_empty));

    // Processor priority from task priority and innermost service level.
    always_comb begin
        if (prio_class(tpr) >= prio_class(stk_top)) ppr_out = tpr;
        else                                         ppr_out = {prio_class(stk_top), 4'h0};
    end

    // Delivery gate: candidate must strictly outrank the processor priority.
    assign pend_valid  = irr_found && (prio_class(irr_top) > prio_class(ppr_out));
    assign pend_vector = irr_top;

    // Event qualification: accept wins over end-of-interrupt.
    assign take   = ack && pend_valid && !stk_full;
    assign retire = eoi && !take && isr_found;

    // One-hot masks for the set and clear operations of this cycle.
    always_comb begin
        req_mask    = req_valid ? (NUM_VEC'(1) << req_vector) : '0;
        take_mask   = take      ? (NUM_VEC'(1) << irr_top)    : '0;
        retire_mask = retire    ? (NUM_VEC'(1) << isr_top)    : '0;
    end

    // Request set: set by strobe, then cleared on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= (irr | req_mask) & ~take_mask;
    end

    // In-service set: set on accept, cleared on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr | take_mask) & ~retire_mask;
    end

    // Task priority register keeps the low byte of each write.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr <= '0;
        else if (tpr_we) tpr <= tpr_wdata[7:0];
    end

    // Sticky overflow flag for an accept with the stack full.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ovf <= 1'b0;
        else if (ack && pend_valid && stk_full)     ovf <= 1'b1;
    end

    assign tpr_out = tpr;
    assign ovf_err = ovf;

    // Word readback of either set.
    assign rd_data = rd_isr ? isr[rd_word*WORD_BITS +: WORD_BITS]
                            : irr[rd_word*WORD_BITS +: WORD_BITS];

    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vector >= 8'(RSVD_VEC)));
    a_r4_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vector[7:4] > ppr_out[7:4]));
    a_r5_tpr_low: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> (tpr_out == $past(tpr_wdata[7:0])));
    a_r6_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_valid && !stk_full) |=>
            (isr[$past(pend_vector)] && !irr[$past(pend_vector)]));
    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

// File: tb/sim_irq_prio_tracker.sv
module sim_irq_prio_tracker;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        pend_valid;
    logic [7:0]  pend_vector;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        tpr_we = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic [7:0]  tpr_out, ppr_out;
    logic        ovf_err;
    logic        rd_isr = 1'b0;
    logic [2:0]  rd_word = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [255:0] m_irr, m_isr;
    logic [7:0]   m_tpr;
    logic         m_ovf;
    int           m_stk [0:DEPTH];
    int           m_sp;

    always #4 clk = ~clk;

    irq_prio_tracker #(.STACK_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .pend_valid(pend_valid), .pend_vector(pend_vector), .ack(ack), .eoi(eoi),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_out(tpr_out), .ppr_out(ppr_out),
        .ovf_err(ovf_err), .rd_isr(rd_isr), .rd_word(rd_word), .rd_data(rd_data));

    function automatic int msb32(input logic [255:0] b);
        int r = -1;
        for (int i = 32; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] m_ppr();
        int top = m_stk[m_sp];
        if ((m_tpr >> 4) >= (top >> 4)) return m_tpr;
        return 8'(top & 8'hF0);
    endfunction

    function automatic bit m_pend_valid();
        int c = msb32(m_irr);
        return (c >= 0) && ((c >> 4) > (m_ppr() >> 4));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input bit sel, input int w, input logic [31:0] exp);
        rd_isr = sel; rd_word = 3'(w); #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic chk_all_words(input string tag);
        for (int w = 0; w < 8; w++) begin
            chk_word(tag, 1'b0, w, m_irr[w*32 +: 32]);
            chk_word(tag, 1'b1, w, m_isr[w*32 +: 32]);
        end
    endtask

    task automatic chk_outputs();
        chk("R4 pend_valid", {31'd0, pend_valid}, {31'd0, m_pend_valid()});
        if (m_pend_valid()) chk("R3 pend_vector", {24'd0, pend_vector}, msb32(m_irr));
        chk("R5 ppr", {24'd0, ppr_out}, {24'd0, m_ppr()});
        chk("R5 tpr", {24'd0, tpr_out}, {24'd0, m_tpr});
        chk("R9 ovf", {31'd0, ovf_err}, {31'd0, m_ovf});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 0; ack = 0; eoi = 0; tpr_we = 0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        m_irr = '0; m_isr = '0; m_tpr = '0; m_ovf = 0; m_sp = 0;
        for (int i = 0; i <= DEPTH; i++) m_stk[i] = 0;
    endtask

    // One clock of stimulus; model updated from pre-edge state.
    task automatic step(input bit rq, input int rv, input bit a, input bit e,
                        input bit tw, input logic [31:0] td);
        int pv;
        bit take;
        req_valid = rq; req_vector = 8'(rv); ack = a; eoi = e;
        tpr_we = tw; tpr_wdata = td;
        pv   = msb32(m_irr);
        take = a && m_pend_valid() && (m_sp < DEPTH);
        if (a && m_pend_valid() && m_sp == DEPTH) m_ovf = 1'b1;
        if (rq) m_irr[rv] = 1'b1;
        if (take) begin
            m_irr[pv] = 1'b0; m_isr[pv] = 1'b1;
            m_sp++; m_stk[m_sp] = pv;
        end else if (e) begin
            int iv = msb32(m_isr);
            if (iv >= 0) begin
                m_isr[iv] = 1'b0;
                if (m_sp > 0) m_sp--;
            end
        end
        if (tw) m_tpr = td[7:0];
        @(posedge clk); #1;
        req_valid = 0; ack = 0; eoi = 0; tpr_we = 0;
        chk_outputs();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk("R1 pend_valid", {31'd0, pend_valid}, 32'd0);
        chk("R1 ppr", {24'd0, ppr_out}, 32'd0);
        chk("R1 tpr", {24'd0, tpr_out}, 32'd0);
        chk("R1 ovf", {31'd0, ovf_err}, 32'd0);
        chk_all_words("R1 words");

        // R2 reserved vector recorded, R3 never offered
        step(1, 5, 0, 0, 0, 0);
        chk_word("R2 word0", 0, 0, 32'h20);
        chk("R3 reserved not offered", {31'd0, pend_valid}, 32'd0);
        step(1, 8'h41, 0, 0, 0, 0);
        step(1, 8'h7F, 0, 0, 0, 0);
        chk("R3 highest", {23'd0, pend_valid, pend_vector}, 32'h17F);

        // R5 low byte kept, R4 strict class compare
        step(0, 0, 0, 0, 1, 32'h1234_5680);
        chk("R5 tpr low byte", {24'd0, tpr_out}, 32'h80);
        chk("R5 ppr=tpr", {24'd0, ppr_out}, 32'h80);
        chk("R4 blocked", {31'd0, pend_valid}, 32'd0);
        step(0, 0, 0, 0, 1, 32'h70);
        chk("R4 equal class blocked", {31'd0, pend_valid}, 32'd0);
        step(0, 0, 0, 0, 1, 32'h6F);
        chk("R4 offered", {23'd0, pend_valid, pend_vector}, 32'h17F);

        // R6 accept
        step(0, 0, 1, 0, 0, 0);
        chk_word("R6 irr cleared", 0, 3, 32'h0);
        chk_word("R6 isr set", 1, 3, 32'h8000_0000);
        chk("R6 ppr from service", {24'd0, ppr_out}, 32'h70);
        step(0, 0, 1, 0, 0, 0);
        chk_word("R6 idle ack isr", 1, 3, 32'h8000_0000);
        chk_word("R6 idle ack irr", 0, 2, 32'h2);

        // R8 request and accept of the same vector
        step(1, 8'h90, 0, 0, 0, 0);
        step(1, 8'h90, 1, 0, 0, 0);
        chk_word("R8 irr cleared", 0, 4, 32'h0);
        chk_word("R8 isr set", 1, 4, 32'h1_0000);
        chk("R8 ppr", {24'd0, ppr_out}, 32'h90);

        // R7 end-of-interrupt
        step(0, 0, 0, 1, 0, 0);
        chk_word("R7 isr cleared", 1, 4, 32'h0);
        chk("R7 ppr restored", {24'd0, ppr_out}, 32'h70);

        // R10 accept and eoi together
        step(1, 8'hA0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk_word("R10 accept applied", 1, 5, 32'h1);
        chk_word("R10 eoi dropped", 1, 3, 32'h8000_0000);
        chk("R10 ppr", {24'd0, ppr_out}, 32'hA0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R7 ppr back to tpr", {24'd0, ppr_out}, 32'h6F);
        step(0, 0, 0, 1, 0, 0);
        chk("R7 empty eoi ppr", {24'd0, ppr_out}, 32'h6F);
        chk_all_words("R7 R11 empty eoi words");

        // R9 overflow
        do_reset();
        for (int k = 3; k <= 6; k++) begin
            step(1, k * 16, 0, 0, 0, 0);
            step(0, 0, 1, 0, 0, 0);
        end
        chk("R9 nested ppr", {24'd0, ppr_out}, 32'h60);
        step(1, 8'h70, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R9 ovf set", {31'd0, ovf_err}, 32'd1);
        chk_word("R9 irr kept", 0, 3, 32'h1_0000);
        chk_word("R9 isr unchanged", 1, 3, 32'h1);
        chk("R9 still offered", {23'd0, pend_valid, pend_vector}, 32'h170);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk_word("R9 accepted later", 1, 3, 32'h1_0000);
        chk("R9 sticky", {31'd0, ovf_err}, 32'd1);

        // Random phase against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            bit rq = ($urandom % 2) == 0;
            int rv = $urandom % 256;
            bit a  = ($urandom % 3) == 0;
            bit e  = ($urandom % 5) == 0;
            bit tw = ($urandom % 16) == 0;
            logic [31:0] td = $urandom & 32'hFFFF_FF8F;
            step(rq, rv, a, e, tw, td);
            if (n % 50 == 0) chk_all_words("R11 random readback");
        end
        chk_all_words("R11 final readback");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule